// File: doc/BRIEF.md
# DDR mode register sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the command pins while it programs the memory's configuration registers, and it decides when the rest of the controller may issue reads. A single `seq_start` pulse is used both for power-up programming and for turning the DLL back on after a debug period with it switched off. In either case the block issues three register loads in a fixed order. The first writes the extended register with the DLL enabled and the chosen drive strength. The second writes the main register with the DLL-reset code. The third writes the main register again with the normal-operation code. Each load waits for the bank-idle indication, and a fixed quiet gap follows it.

After every DLL enable, `rd_ready` stays low until CKE has been high for a full lockout window of consecutive clocks. The same lockout starts again, with no register load, when the controller reports a self-refresh exit. A drop of CKE also starts the count again from zero.

Software-chosen main-register loads arrive on a small valid/ready stream. The block accepts an item only while it is idle and no start is requested in the same cycle. Back-pressure is held for the whole of a running sequence or load. An item whose upper code is reserved is consumed and discarded, and an error strobe reports it.

Top module: `mrs_seq`

## Requirements
- R1: While reset is held and just after it, the command pins show NOP (cs_n low, ras_n, cas_n and we_n high), `ba` and `addr` are zero, and `busy`, `rd_ready` and `rsv_err` are low.
- R2: A start issues three loads in order. The first goes to bank code 01 with addr bit 0 = 0 (DLL on), bit 1 = `cfg_drive` and all other bits zero. The second goes to bank code 00 with bit 8 = 1, bits 12:9 and bit 7 zero, and bits 6:0 = `cfg_mode`. The third goes to bank code 00 with bits 12:7 zero and bits 6:0 = `cfg_mode`. Bank code is written {BA1,BA0}.
- R3: A load drives cs_n, ras_n, cas_n and we_n all low for exactly one cycle. Every other cycle is NOP, with `ba` and `addr` at zero.
- R4: A load appears only in the cycle after a clock edge at which `all_idle` was high. While `all_idle` stays low, the block waits with no limit.
- R5: After each load at least `T_MRD` NOP cycles follow before the next command. With `all_idle` held high, the next load of a sequence follows after exactly `T_MRD` NOP cycles.
- R6: `busy` is high from the cycle after a start or request is taken until the gap after its final load ends. A `seq_start` seen while `busy` is high is ignored.
- R7: `rd_ready` rises only after CKE has been sampled high at `LOCK_CYC` consecutive edges following the extended-register load, and exactly at that point. Before the first DLL enable it stays low.
- R8: CKE sampled low at an edge drops `rd_ready` and restarts the count from zero.
- R9: A `sr_exit` strobe drops `rd_ready` and restarts the lockout without issuing any load.
- R10: `usr_ready` is high exactly when the block is idle and `seq_start` is low. An accepted item whose bits 12:7 are 000000 or 000010 goes out as one load to bank code 00 carrying the item's address, subject to R4 and R5.
- R11: An accepted item with any other value in bits 12:7 issues no load, and `rsv_err` goes high for exactly the next cycle.
- R12: `rd_ready` is low while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_start | input | 1 | Start the three-load DLL enable sequence |
| cfg_mode | input | 7 | Burst and latency settings for main-register bits 6:0 |
| cfg_drive | input | 1 | Output drive strength setting |
| usr_valid | input | 1 | User main-register load request valid |
| usr_ready | output | 1 | Request accepted this cycle when valid |
| usr_addr | input | 13 | Requested main-register address value |
| all_idle | input | 1 | All banks idle and no burst active |
| cke | input | 1 | Current clock-enable level sent to the memory |
| sr_exit | input | 1 | Strobe: memory has left self refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address {BA1,BA0} |
| addr | output | 13 | Address bus A12..A0 |
| busy | output | 1 | Sequence or user load in progress |
| rd_ready | output | 1 | Reads may be issued |
| rsv_err | output | 1 | One-cycle strobe for a reserved request |

## Verification
The sequence is run four ways. Bank-idle held high shows the exact load order, the field contents and the gap length. Bank-idle held low shows that the block stalls instead of issuing. A second start during a running sequence shows that requests are ignored while busy, and a start after the lockout has run out shows that `rd_ready` drops at once. The lockout is timed from three different restart sources (extended-register load, a single-cycle CKE drop, and self-refresh exit), and each must give exactly the window length. User requests with the two legal upper codes and with two reserved codes tell a forwarded load apart from a discarded one with an error strobe.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int ADDR_W = 13;
  localparam int MODE_W = 7;
  localparam int HI_W   = ADDR_W - MODE_W;

  localparam logic [HI_W-1:0] HI_NORMAL = 6'b000000;
  localparam logic [HI_W-1:0] HI_DLLRST = 6'b000010;

  localparam logic [1:0] BANK_MAIN = 2'b00;
  localparam logic [1:0] BANK_EXT  = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_GAP} seq_state_t;
  typedef enum logic [1:0] {STEP_EXT, STEP_RST, STEP_NORM, STEP_USER} seq_step_t;

  function automatic logic mr_code_ok(input logic [HI_W-1:0] hi);
    return (hi == HI_NORMAL) || (hi == HI_DLLRST);
  endfunction
endpackage

// File: rtl/mrs_addr_gen.sv
module mrs_addr_gen
  import mrs_pkg::*;
(
  input  seq_step_t          step,
  input  logic [MODE_W-1:0]  mode,
  input  logic               drive,
  input  logic [ADDR_W-1:0]  usr,
  output logic [1:0]         bank,
  output logic [ADDR_W-1:0]  value
);
  always_comb begin
    bank  = BANK_MAIN;
    value = '0;
    unique case (step)
      STEP_EXT: begin
        bank     = BANK_EXT;
        value[0] = 1'b0;
        value[1] = drive;
      end
      STEP_RST:  value = {HI_DLLRST, mode};
      STEP_NORM: value = {HI_NORMAL, mode};
      default:   value = usr;
    endcase
  end
endmodule

// File: rtl/mrs_lockout.sv
module mrs_lockout #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cke,
  output logic done
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LOCK_CYC);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (!cke) begin
      cnt <= '0;
    end else if (cnt != CNT_END) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = armed && (cnt == CNT_END);
endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int T_MRD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start,
  input  logic              usr_valid,
  input  logic [ADDR_W-1:0] usr_addr,
  input  logic              all_idle,
  output logic              usr_ready,
  output logic              issue,
  output seq_step_t         step,
  output logic [ADDR_W-1:0] usr_hold,
  output logic              busy,
  output logic              rsv_err
);
  localparam int GAP_W = (T_MRD > 1) ? $clog2(T_MRD) : 1;
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(T_MRD - 1);

  seq_state_t       state;
  logic [GAP_W-1:0] gap;

  assign usr_ready = (state == ST_IDLE) && !seq_start;
  assign issue     = (state == ST_ARM) && all_idle;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= STEP_EXT;
      gap      <= '0;
      usr_hold <= '0;
      rsv_err  <= 1'b0;
    end else begin
      rsv_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (seq_start) begin
            step  <= STEP_EXT;
            state <= ST_ARM;
          end else if (usr_valid) begin
            if (mr_code_ok(usr_addr[ADDR_W-1:MODE_W])) begin
              usr_hold <= usr_addr;
              step     <= STEP_USER;
              state    <= ST_ARM;
            end else begin
              rsv_err <= 1'b1;
            end
          end
        end
        ST_ARM: begin
          if (all_idle) begin
            gap   <= GAP_INIT;
            state <= ST_GAP;
          end
        end
        default: begin
          if (gap != '0) begin
            gap <= gap - 1'b1;
          end else begin
            unique case (step)
              STEP_EXT: begin step <= STEP_RST;  state <= ST_ARM; end
              STEP_RST: begin step <= STEP_NORM; state <= ST_ARM; end
              default:  state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import mrs_pkg::*;
#(
  parameter int T_MRD    = 2,
  parameter int LOCK_CYC = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seq_start,
  input  logic [6:0]  cfg_mode,
  input  logic        cfg_drive,
  input  logic        usr_valid,
  output logic        usr_ready,
  input  logic [12:0] usr_addr,
  input  logic        all_idle,
  input  logic        cke,
  input  logic        sr_exit,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        busy,
  output logic        rd_ready,
  output logic        rsv_err
);
  logic              issue;
  seq_step_t         step;
  logic [ADDR_W-1:0] usr_hold;
  logic [1:0]        gen_ba;
  logic [ADDR_W-1:0] gen_addr;
  logic              lock_done;
  logic              relock;

  mrs_ctrl #(.T_MRD(T_MRD)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .seq_start(seq_start),
    .usr_valid(usr_valid),
    .usr_addr (usr_addr),
    .all_idle (all_idle),
    .usr_ready(usr_ready),
    .issue    (issue),
    .step     (step),
    .usr_hold (usr_hold),
    .busy     (busy),
    .rsv_err  (rsv_err)
  );

  mrs_addr_gen u_gen (
    .step (step),
    .mode (cfg_mode),
    .drive(cfg_drive),
    .usr  (usr_hold),
    .bank (gen_ba),
    .value(gen_addr)
  );

  assign relock = sr_exit || (issue && (step == STEP_EXT));

  mrs_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(relock),
    .cke    (cke),
    .done   (lock_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      ba   <= '0;
      addr <= '0;
    end else if (issue) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0000;
      ba   <= gen_ba;
      addr <= gen_addr;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
      ba   <= '0;
      addr <= '0;
    end
  end

  assign rd_ready = lock_done && !busy;
endmodule

// File: rtl/mrs_seq_chk.sv
module mrs_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [1:0] ba,
  input logic [5:0] mr_hi,
  input logic       emr_dll_off,
  input logic       all_idle,
  input logic       cke,
  input logic       sr_exit,
  input logic       usr_valid,
  input logic       usr_ready,
  input logic [5:0] usr_hi,
  input logic       busy,
  input logic       rd_ready,
  input logic       rsv_err
);
  logic lmr;
  assign lmr = !cs_n && !ras_n && !cas_n && !we_n;

  a_r3_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |=> (!cs_n && ras_n && cas_n && we_n));

  a_r4_idle_before_load: assert property (@(posedge clk) disable iff (!rst_n)
    lmr |-> $past(all_idle));

  a_r2_main_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr && ba == 2'b00) |-> (mr_hi == 6'b000000 || mr_hi == 6'b000010));

  a_r2_ext_dll_on: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr && ba == 2'b01) |-> !emr_dll_off);

  a_r7_ready_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> $past(cke));

  a_r9_srx_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> !rd_ready);

  a_r11_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_valid && usr_ready && !(usr_hi == 6'b000000 || usr_hi == 6'b000010)) |=> rsv_err);

  a_r12_busy_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_ready);
endmodule

bind mrs_seq mrs_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .mr_hi      (addr[12:7]),
  .emr_dll_off(addr[0]),
  .all_idle   (all_idle),
  .cke        (cke),
  .sr_exit    (sr_exit),
  .usr_valid  (usr_valid),
  .usr_ready  (usr_ready),
  .usr_hi     (usr_addr[12:7]),
  .busy       (busy),
  .rd_ready   (rd_ready),
  .rsv_err    (rsv_err)
);

// File: tb/test_mrs_seq.sv
`timescale 1ns/1ps
module test_mrs_seq;
  localparam int T_MRD = 2;
  localparam int LOCK  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_start = 1'b0;
  logic [6:0] cfg_mode = 7'h32;
  logic cfg_drive = 1'b1;
  logic usr_valid = 1'b0;
  logic usr_ready;
  logic [12:0] usr_addr = '0;
  logic all_idle = 1'b1;
  logic cke = 1'b1;
  logic sr_exit = 1'b0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] addr;
  logic busy, rd_ready, rsv_err;

  always #2.5 clk = ~clk;

  mrs_seq #(.T_MRD(T_MRD), .LOCK_CYC(LOCK)) i_mrs_seq (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .cfg_mode(cfg_mode),
    .cfg_drive(cfg_drive), .usr_valid(usr_valid), .usr_ready(usr_ready),
    .usr_addr(usr_addr), .all_idle(all_idle), .cke(cke), .sr_exit(sr_exit),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr(addr), .busy(busy), .rd_ready(rd_ready), .rsv_err(rsv_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lmr_cyc[$];
  logic [14:0] lmr_val[$];
  int rise_cyc = -1;
  int fall_cyc = -1;
  int rsv_seen = 0;
  logic prev_rdy = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state = 0;  // 0 idle, 1 waiting for idle banks, 2 quiet gap
  int m_step = 0;   // 0 ext, 1 dll reset, 2 normal, 3 user
  int m_gap = 0;
  int m_cnt = 0;
  bit m_on = 1'b0;
  logic [12:0] m_usr = '0;
  bit e_lmr = 1'b0;
  bit e_rsv = 1'b0;
  logic [1:0] e_ba = '0;
  logic [12:0] e_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_step = 0; m_gap = 0; m_cnt = 0; m_on = 0;
      e_lmr = 0; e_rsv = 0; e_ba = 0; e_addr = 0;
    end else begin
      e_lmr = 0; e_rsv = 0; e_ba = 0; e_addr = 0;
      if (sr_exit) begin m_cnt = 0; m_on = 1; end
      else if (!cke) m_cnt = 0;
      else if (m_cnt < LOCK) m_cnt = m_cnt + 1;
      case (m_state)
        0: begin
          if (seq_start) begin m_step = 0; m_state = 1; end
          else if (usr_valid) begin
            if (usr_addr[12:7] == 6'd0 || usr_addr[12:7] == 6'd2) begin
              m_usr = usr_addr; m_step = 3; m_state = 1;
            end else e_rsv = 1;
          end
        end
        1: begin
          if (all_idle) begin
            e_lmr = 1;
            case (m_step)
              0: begin e_ba = 2'b01; e_addr = {11'd0, cfg_drive, 1'b0};
                       m_cnt = 0; m_on = 1; end
              1: begin e_ba = 2'b00; e_addr = 13'h100 | {6'd0, cfg_mode}; end
              2: begin e_ba = 2'b00; e_addr = {6'd0, cfg_mode}; end
              default: begin e_ba = 2'b00; e_addr = m_usr; end
            endcase
            m_gap = T_MRD - 1;
            m_state = 2;
          end
        end
        default: begin
          if (m_gap > 0) m_gap = m_gap - 1;
          else if (m_step < 2) begin m_step = m_step + 1; m_state = 1; end
          else m_state = 0;
        end
      endcase
    end
  end

  // monitor and per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk({cs_n, ras_n, cas_n, we_n} == (e_lmr ? 4'b0000 : 4'b0111), "R3", "cmd pins",
          {cs_n, ras_n, cas_n, we_n}, e_lmr ? 4'b0000 : 4'b0111);
      chk({ba, addr} == {e_ba, e_addr}, "R2", "bank/addr", {ba, addr}, {e_ba, e_addr});
      chk(busy == (m_state != 0), "R6", "busy", busy, m_state != 0);
      chk(rd_ready == (m_on && m_cnt == LOCK && m_state == 0), "R7", "rd_ready",
          rd_ready, m_on && m_cnt == LOCK && m_state == 0);
      chk(rsv_err == e_rsv, "R11", "rsv_err", rsv_err, e_rsv);
      chk(usr_ready == (m_state == 0 && !seq_start), "R10", "usr_ready",
          usr_ready, m_state == 0 && !seq_start);
      if (!cs_n && !ras_n && !cas_n && !we_n) begin
        lmr_cyc.push_back(cyc);
        lmr_val.push_back({ba, addr});
      end
      if (rd_ready && !prev_rdy) rise_cyc = cyc;
      if (!rd_ready && prev_rdy) fall_cyc = cyc;
      if (rsv_err) rsv_seen++;
      prev_rdy = rd_ready;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    tick(1); seq_start = 1'b1;
    tick(1); seq_start = 1'b0;
  endtask

  task automatic send_usr(input logic [12:0] a);
    tick(1); usr_valid = 1'b1; usr_addr = a;
    tick(1); usr_valid = 1'b0;
  endtask

  bit finished = 1'b0;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n0;
    int emr;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n, ba, addr} == {4'b0111, 15'd0}, "R1", "pins in reset",
        {cs_n, ras_n, cas_n, we_n, ba, addr}, {4'b0111, 15'd0});
    chk({busy, rd_ready, rsv_err} == 3'b000, "R1", "status in reset",
        {busy, rd_ready, rsv_err}, 0);
    tick(1); rst_n = 1'b1;
    tick(2);
    chk({cs_n, ras_n, cas_n, we_n, busy, rd_ready} == 6'b011100, "R1", "after reset",
        {cs_n, ras_n, cas_n, we_n, busy, rd_ready}, 6'b011100);

    // R2/R5/R6: sequence, second start while busy ignored
    n0 = lmr_cyc.size();
    pulse_start();
    tick(2);
    pulse_start();
    tick(20);
    chk(lmr_cyc.size() - n0 == 3, "R6", "load count", lmr_cyc.size() - n0, 3);
    if (lmr_cyc.size() - n0 == 3) begin
      chk(lmr_val[n0] == {2'b01, 13'h0002}, "R2", "ext load", lmr_val[n0], {2'b01, 13'h0002});
      chk(lmr_val[n0+1] == {2'b00, 13'h0132}, "R2", "dll reset load", lmr_val[n0+1], {2'b00, 13'h0132});
      chk(lmr_val[n0+2] == {2'b00, 13'h0032}, "R2", "normal load", lmr_val[n0+2], {2'b00, 13'h0032});
      chk(lmr_cyc[n0+1] - lmr_cyc[n0] == T_MRD + 1, "R5", "gap 1",
          lmr_cyc[n0+1] - lmr_cyc[n0], T_MRD + 1);
      chk(lmr_cyc[n0+2] - lmr_cyc[n0+1] == T_MRD + 1, "R5", "gap 2",
          lmr_cyc[n0+2] - lmr_cyc[n0+1], T_MRD + 1);
      emr = lmr_cyc[n0];
      tick(LOCK + 10);
      chk(rise_cyc - emr == LOCK, "R7", "lockout length", rise_cyc - emr, LOCK);
    end

    // R8: one-cycle CKE drop
    tick(1); cke = 1'b0;
    tick(1); cke = 1'b1;
    tick(LOCK + 10);
    chk(rise_cyc - fall_cyc == LOCK, "R8", "restart after cke drop", rise_cyc - fall_cyc, LOCK);
    chk(rd_ready == 1'b1, "R8", "ready again", rd_ready, 1);

    // R9: self refresh exit
    n0 = lmr_cyc.size();
    tick(1); sr_exit = 1'b1;
    tick(1); sr_exit = 1'b0;
    tick(LOCK + 10);
    chk(rise_cyc - fall_cyc == LOCK, "R9", "restart after sr exit", rise_cyc - fall_cyc, LOCK);
    chk(lmr_cyc.size() == n0, "R9", "no load on sr exit", lmr_cyc.size(), n0);

    // R12: start while ready
    pulse_start();
    @(negedge clk);
    chk(busy && !rd_ready, "R12", "ready low while busy", {busy, rd_ready}, 2'b10);
    tick(20);

    // R4: banks busy
    n0 = lmr_cyc.size();
    all_idle = 1'b0;
    pulse_start();
    tick(30);
    chk(lmr_cyc.size() == n0, "R4", "no load while banks busy", lmr_cyc.size(), n0);
    chk(busy == 1'b1, "R4", "waiting busy", busy, 1);
    all_idle = 1'b1;
    tick(20);
    chk(lmr_cyc.size() - n0 == 3, "R4", "loads after idle", lmr_cyc.size() - n0, 3);

    // R10: legal user loads
    n0 = lmr_cyc.size();
    send_usr(13'h0045);
    tick(10);
    send_usr(13'h0163);
    tick(10);
    chk(lmr_cyc.size() - n0 == 2, "R10", "user load count", lmr_cyc.size() - n0, 2);
    if (lmr_cyc.size() - n0 == 2) begin
      chk(lmr_val[n0] == {2'b00, 13'h0045}, "R10", "user normal", lmr_val[n0], {2'b00, 13'h0045});
      chk(lmr_val[n0+1] == {2'b00, 13'h0163}, "R10", "user dll reset", lmr_val[n0+1], {2'b00, 13'h0163});
    end

    // R11: reserved user codes
    n0 = lmr_cyc.size();
    send_usr(13'h0080);
    tick(5);
    send_usr(13'h1003);
    tick(5);
    chk(lmr_cyc.size() == n0, "R11", "reserved not issued", lmr_cyc.size(), n0);
    chk(rsv_seen == 2, "R11", "error strobes", rsv_seen, 2);

    finished = 1'b1;
    finish_run();
  end
endmodule